// File: doc/BRIEF.md
# Multi-Sector Erase Sequencer with Suspend

This block controls a flash erase that can cover several sectors at once. The first sector-erase strobe opens a load window and marks its sector in a selection mask. Each later sector-erase strobe marks one more sector and starts the window timer again. When a full window of microsecond ticks passes with no new sector, the block pulses an erase start and moves through a pre-program phase and then an erase phase. Each phase ends when the erase engine reports done.

A suspend strobe pauses the erase. If the window is still open, the block enters the suspended phase in the next cycle. If pre-program or erase is already running, the block first spends a fixed number of microsecond ticks in a suspending phase, and then enters the suspended phase. While suspended, the selection mask stays visible so that surrounding logic can allow access to the sectors that are not selected. A resume strobe continues the erase. A hardware reset input abandons the erase at once. An engine timeout locks the block in an error phase, and only a reset command clears it.

Top module: `erase_seq_ctrl`

## Requirements
- R1: After rst_ni is released, phase_o reads 0 (idle), sel_mask_o is all zeros, and erase_start_o, abort_o, pause_o and window_open_o are low.
- R2: A sector-add strobe in idle or in the window phase sets bit sector_idx_i of sel_mask_o, and phase_o reads 1 (window) with window_open_o high from the next cycle.
- R3: The window closes on the WINDOW_US-th tick_us_i after the most recent accepted sector-add strobe. Each accepted add restarts that count. At the close, erase_start_o is high for exactly one cycle and phase_o reads 2 (pre-program).
- R4: A strobe on cmd_other_i during the window returns phase_o to 0 and clears sel_mask_o in the next cycle, with abort_o high for one cycle.
- R5: A suspend strobe during the window makes phase_o read 5 (suspended), with window_open_o low and pause_o high, in the next cycle. A later resume gives a one-cycle erase_start_o pulse and phase 2.
- R6: A suspend strobe in phase 2 or 3 (erase) gives phase 4 (suspending) with pause_o high in the next cycle. Phase 5 follows on the SUSP_US-th tick after the strobe.
- R7: A resume strobe in phase 5 returns to the phase in which the suspend was taken (2 or 3). In any other phase it changes no output.
- R8: A suspend can be taken again after a resume, and it follows R6 again.
- R9: eng_done_i in phase 2 moves the block to phase 3. eng_done_i in phase 3 returns it to phase 0 and clears sel_mask_o.
- R10: sel_mask_o is unchanged through phases 2 to 5. Sector-add strobes in those phases are ignored.
- R11: hw_reset_i in any phase other than idle gives phase 0 and a cleared mask in the next cycle, with abort_o high for one cycle.
- R12: eng_timeout_i in phases 2, 3 or 4 gives phase 6 (error). Phase 6 holds against every strobe except cmd_reset_i, which returns the block to phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_reset_i | input | 1 | Hardware reset abort, synchronous |
| cmd_add_i | input | 1 | Decoded sector-erase strobe |
| cmd_suspend_i | input | 1 | Decoded suspend strobe |
| cmd_resume_i | input | 1 | Decoded resume strobe |
| cmd_other_i | input | 1 | Any other decoded command |
| cmd_reset_i | input | 1 | Decoded reset command |
| sector_idx_i | input | IDX_W | Sector index carried with cmd_add_i |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| eng_done_i | input | 1 | Engine finished the current phase |
| eng_timeout_i | input | 1 | Engine gave up |
| sel_mask_o | output | N_SECT | Selected sector mask |
| erase_start_o | output | 1 | One-cycle erase start pulse |
| pause_o | output | 1 | Engine pause request |
| abort_o | output | 1 | One-cycle abort pulse |
| window_open_o | output | 1 | Load window is open |
| phase_o | output | 3 | Phase code: 0 idle, 1 window, 2 pre-program, 3 erase, 4 suspending, 5 suspended, 6 error |

## Verification
A wrong window count shows on phase_o and erase_start_o at the very tick where the close should or should not happen, so the per-cycle comparison catches it within one cycle of that tick. A wrong saved resume phase stays hidden until the first resume, and then phase_o shows 2 instead of 3 or the other way round. A mask that leaks a bit or fails to clear shows on sel_mask_o in the cycle after the strobe that caused it, including an add strobe sent while suspended.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_WINDOW     = 3'd1,
    PH_PREPROG    = 3'd2,
    PH_ERASE      = 3'd3,
    PH_SUSPENDING = 3'd4,
    PH_SUSPENDED  = 3'd5,
    PH_ERROR      = 3'd6
  } phase_e;
endpackage

// File: rtl/us_downcnt.sv
module us_downcnt #(
  parameter int MAX_COUNT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(MAX_COUNT + 1);
  localparam logic [CW-1:0] LOADV = CW'(MAX_COUNT);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= LOADV;
    else if (clr_i)                      cnt_q <= '0;
    else if (tick_i && cnt_q != '0)      cnt_q <= cnt_q - ONE;
  end

  assign expire_o = tick_i && (cnt_q == ONE) && !load_i && !clr_i;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOADV);  // R3
  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == LOADV);  // R3
endmodule

// File: rtl/sector_sel_mask.sv
module sector_sel_mask #(
  parameter int N_SECT = 8,
  localparam int IDX_W = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              clr_i,
  output logic [N_SECT-1:0] mask_o
);
  for (genvar g = 0; g < N_SECT; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bit_q <= 1'b0;
      else if (clr_i)                              bit_q <= 1'b0;
      else if (set_i && idx_i == IDX_W'(g))        bit_q <= 1'b1;
    end
    assign mask_o[g] = bit_q;
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mask_o));  // R10
  AST_MASK_ONEBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> $countones(mask_o ^ $past(mask_o)) <= 1);  // R2
endmodule

// File: rtl/erase_phase_fsm.sv
module erase_phase_fsm
  import erase_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   hw_reset_i,
  input  logic   add_i,
  input  logic   susp_i,
  input  logic   resume_i,
  input  logic   other_i,
  input  logic   rstcmd_i,
  input  logic   timeout_i,
  input  logic   done_i,
  input  logic   win_exp_i,
  input  logic   sus_exp_i,
  output phase_e phase_o,
  output logic   start_o,
  output logic   abort_o,
  output logic   add_ok_o,
  output logic   mask_clr_o,
  output logic   win_clr_o,
  output logic   sus_load_o,
  output logic   sus_clr_o
);
  phase_e ph_q, ph_d, ret_q, ret_d;
  logic start_q, start_d, abort_q, abort_d;

  always_comb begin
    ph_d       = ph_q;
    ret_d      = ret_q;
    start_d    = 1'b0;
    abort_d    = 1'b0;
    add_ok_o   = 1'b0;
    mask_clr_o = 1'b0;
    sus_load_o = 1'b0;
    if (hw_reset_i) begin
      ph_d       = PH_IDLE;
      mask_clr_o = 1'b1;
      abort_d    = (ph_q != PH_IDLE);
    end else begin
      unique case (ph_q)
        PH_IDLE: if (add_i) begin
          add_ok_o = 1'b1;
          ph_d     = PH_WINDOW;
        end
        PH_WINDOW: begin
          if (other_i) begin
            ph_d       = PH_IDLE;
            mask_clr_o = 1'b1;
            abort_d    = 1'b1;
          end else if (susp_i) begin
            ph_d  = PH_SUSPENDED;
            ret_d = PH_WINDOW;
          end else if (add_i) begin
            add_ok_o = 1'b1;
          end else if (win_exp_i) begin
            ph_d    = PH_PREPROG;
            start_d = 1'b1;
          end
        end
        PH_PREPROG, PH_ERASE: begin
          if (timeout_i) ph_d = PH_ERROR;
          else if (susp_i) begin
            ph_d       = PH_SUSPENDING;
            ret_d      = ph_q;
            sus_load_o = 1'b1;
          end else if (done_i) begin
            if (ph_q == PH_PREPROG) ph_d = PH_ERASE;
            else begin
              ph_d       = PH_IDLE;
              mask_clr_o = 1'b1;
            end
          end
        end
        PH_SUSPENDING: begin
          if (timeout_i)      ph_d = PH_ERROR;
          else if (sus_exp_i) ph_d = PH_SUSPENDED;
        end
        PH_SUSPENDED: if (resume_i) begin
          if (ret_q == PH_WINDOW) begin
            ph_d    = PH_PREPROG;
            start_d = 1'b1;
          end else begin
            ph_d = ret_q;
          end
        end
        PH_ERROR: if (rstcmd_i) begin
          ph_d       = PH_IDLE;
          mask_clr_o = 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      ret_q   <= PH_WINDOW;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      ret_q   <= ret_d;
      start_q <= start_d;
      abort_q <= abort_d;
    end
  end

  assign phase_o   = ph_q;
  assign start_o   = start_q;
  assign abort_o   = abort_q;
  assign win_clr_o = (ph_q != PH_WINDOW);
  assign sus_clr_o = (ph_q != PH_SUSPENDING);

  AST_HWRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_reset_i |=> ph_q == PH_IDLE);  // R11
  AST_OTHER_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WINDOW && other_i && !hw_reset_i) |=> (ph_q == PH_IDLE && abort_q));  // R4
  AST_WIN_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WINDOW && susp_i && !other_i && !hw_reset_i) |=> ph_q == PH_SUSPENDED);  // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_ERROR && !rstcmd_i && !hw_reset_i) |=> ph_q == PH_ERROR);  // R12
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);  // R3
  AST_RESUME_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SUSPENDED && resume_i && !hw_reset_i && ret_q != PH_WINDOW)
      |=> (ph_q == PH_PREPROG || ph_q == PH_ERASE));  // R7
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int N_SECT    = 8,
  parameter int WINDOW_US = 50,
  parameter int SUSP_US   = 20,
  localparam int IDX_W = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_reset_i,
  input  logic              cmd_add_i,
  input  logic              cmd_suspend_i,
  input  logic              cmd_resume_i,
  input  logic              cmd_other_i,
  input  logic              cmd_reset_i,
  input  logic [IDX_W-1:0]  sector_idx_i,
  input  logic              tick_us_i,
  input  logic              eng_done_i,
  input  logic              eng_timeout_i,
  output logic [N_SECT-1:0] sel_mask_o,
  output logic              erase_start_o,
  output logic              pause_o,
  output logic              abort_o,
  output logic              window_open_o,
  output logic [2:0]        phase_o
);
  phase_e phase;
  logic win_exp, sus_exp, add_ok, mask_clr, win_clr, sus_load, sus_clr;

  erase_phase_fsm u_fsm (
    .clk_i, .rst_ni, .hw_reset_i,
    .add_i      (cmd_add_i),
    .susp_i     (cmd_suspend_i),
    .resume_i   (cmd_resume_i),
    .other_i    (cmd_other_i),
    .rstcmd_i   (cmd_reset_i),
    .timeout_i  (eng_timeout_i),
    .done_i     (eng_done_i),
    .win_exp_i  (win_exp),
    .sus_exp_i  (sus_exp),
    .phase_o    (phase),
    .start_o    (erase_start_o),
    .abort_o    (abort_o),
    .add_ok_o   (add_ok),
    .mask_clr_o (mask_clr),
    .win_clr_o  (win_clr),
    .sus_load_o (sus_load),
    .sus_clr_o  (sus_clr)
  );

  us_downcnt #(.MAX_COUNT(WINDOW_US)) u_win_tmr (
    .clk_i, .rst_ni,
    .load_i   (add_ok),
    .clr_i    (win_clr),
    .tick_i   (tick_us_i),
    .expire_o (win_exp)
  );

  us_downcnt #(.MAX_COUNT(SUSP_US)) u_sus_tmr (
    .clk_i, .rst_ni,
    .load_i   (sus_load),
    .clr_i    (sus_clr),
    .tick_i   (tick_us_i),
    .expire_o (sus_exp)
  );

  sector_sel_mask #(.N_SECT(N_SECT)) u_mask (
    .clk_i, .rst_ni,
    .set_i  (add_ok),
    .idx_i  (sector_idx_i),
    .clr_i  (mask_clr),
    .mask_o (sel_mask_o)
  );

  assign phase_o       = phase;
  assign window_open_o = (phase == PH_WINDOW);
  assign pause_o       = (phase == PH_SUSPENDING) || (phase == PH_SUSPENDED);

  AST_IGNORE_ADD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase inside {PH_PREPROG, PH_ERASE, PH_SUSPENDING, PH_SUSPENDED} && !hw_reset_i && !eng_done_i)
      |=> $stable(sel_mask_o));  // R10
  AST_PAUSE_AFTER_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase == PH_PREPROG || phase == PH_ERASE) && cmd_suspend_i && !eng_timeout_i && !hw_reset_i)
      |=> pause_o && phase == PH_SUSPENDING);  // R6
endmodule

// File: tb/erase_seq_ctrl_test.sv
module erase_seq_ctrl_test;
  localparam int NS = 8;
  localparam int WUS = 50;
  localparam int SUS = 20;

  logic clk = 0, rst_n = 0;
  logic hw_rst = 0, c_add = 0, c_susp = 0, c_res = 0, c_oth = 0, c_rst = 0;
  logic [2:0] s_idx = 0;
  logic tick = 0, e_done = 0, e_to = 0;
  logic [NS-1:0] mask;
  logic start, pause, abort, wopen;
  logic [2:0] phase;

  int tests = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  erase_seq_ctrl #(.N_SECT(NS), .WINDOW_US(WUS), .SUSP_US(SUS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hw_reset_i(hw_rst),
    .cmd_add_i(c_add), .cmd_suspend_i(c_susp), .cmd_resume_i(c_res),
    .cmd_other_i(c_oth), .cmd_reset_i(c_rst), .sector_idx_i(s_idx),
    .tick_us_i(tick), .eng_done_i(e_done), .eng_timeout_i(e_to),
    .sel_mask_o(mask), .erase_start_o(start), .pause_o(pause),
    .abort_o(abort), .window_open_o(wopen), .phase_o(phase));

  // Behavioural reference
  int m_ph = 0, m_ret = 1, m_win = 0, m_sus = 0;
  bit [NS-1:0] m_mask = '0;
  bit m_start = 0, m_abort = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_ret = 1; m_win = 0; m_sus = 0; m_mask = '0; m_start = 0; m_abort = 0;
    end else begin
      int nph;
      bit wexp, sexp;
      nph = m_ph; m_start = 0; m_abort = 0;
      wexp = (m_ph == 1) && tick && (m_win == 1);
      sexp = (m_ph == 4) && tick && (m_sus == 1);
      if (m_ph == 1 && tick && m_win > 0) m_win--;
      if (m_ph == 4 && tick && m_sus > 0) m_sus--;
      if (hw_rst) begin
        m_abort = (m_ph != 0); nph = 0; m_mask = '0;
      end else if (m_ph == 0) begin
        if (c_add) begin nph = 1; m_mask[s_idx] = 1; m_win = WUS; end
      end else if (m_ph == 1) begin
        if (c_oth) begin nph = 0; m_mask = '0; m_abort = 1; end
        else if (c_susp) begin nph = 5; m_ret = 1; end
        else if (c_add) begin m_mask[s_idx] = 1; m_win = WUS; end
        else if (wexp) begin nph = 2; m_start = 1; end
      end else if (m_ph == 2 || m_ph == 3) begin
        if (e_to) nph = 6;
        else if (c_susp) begin nph = 4; m_ret = m_ph; m_sus = SUS; end
        else if (e_done) begin
          if (m_ph == 2) nph = 3; else begin nph = 0; m_mask = '0; end
        end
      end else if (m_ph == 4) begin
        if (e_to) nph = 6; else if (sexp) nph = 5;
      end else if (m_ph == 5) begin
        if (c_res) begin
          if (m_ret == 1) begin nph = 2; m_start = 1; end else nph = m_ret;
        end
      end else if (m_ph == 6) begin
        if (c_rst) begin nph = 0; m_mask = '0; end
      end
      if (nph != 1) m_win = 0;
      if (nph != 4) m_sus = 0;
      m_ph = nph;
    end
  end

  // Per-cycle comparison and tick generation, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    tick = (cyc % 4 == 0);
    if (rst_n && !done_flag) begin
      tests++;
      if (phase !== 3'(m_ph) || mask !== m_mask || start !== m_start || abort !== m_abort ||
          wopen !== (m_ph == 1) || pause !== (m_ph == 4 || m_ph == 5)) begin
        fails++;
        $display("FAIL R2/R3/R6/R9 per-cycle cyc=%0d actual ph=%0d mask=%h st=%0b ab=%0b expected ph=%0d mask=%h st=%0b ab=%0b",
                 cyc, phase, mask, start, abort, m_ph, m_mask, m_start, m_abort);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0 add,1 suspend,2 resume,3 other,4 reset cmd,5 done,6 timeout,7 hw reset
  task automatic strobe(input int kind, input int idx = 0);
    @(negedge clk);
    s_idx = 3'(idx);
    case (kind)
      0: c_add = 1; 1: c_susp = 1; 2: c_res = 1; 3: c_oth = 1;
      4: c_rst = 1; 5: e_done = 1; 6: e_to = 1; default: hw_rst = 1;
    endcase
    @(negedge clk);
    {c_add, c_susp, c_res, c_oth, c_rst, e_done, e_to, hw_rst} = '0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!start && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    cyc_n(3);
    chk(phase, 0, "R1 reset phase");
    chk(int'(mask), 0, "R1 reset mask");
    chk(int'({start, abort, pause, wopen}), 0, "R1 reset strobes");
    rst_n = 1;
    cyc_n(2);

    strobe(0, 2);
    chk(phase, 1, "R2 window phase");
    chk(int'(wopen), 1, "R2 window flag");
    chk(int'(mask), 8'h04, "R2 mask bit");
    cyc_n(30);
    strobe(0, 5);
    chk(phase, 1, "R3 window retriggered");
    chk(int'(mask), 8'h24, "R2 second bit");
    wait_start(n);
    chk(int'(n >= 4*WUS - 8 && n <= 4*WUS + 4), 1, "R3 window length");
    chk(int'(start), 1, "R3 start pulse");
    cyc_n(1);
    chk(int'(start), 0, "R3 start single cycle");
    chk(phase, 2, "R3 preprog phase");

    strobe(5);
    chk(phase, 3, "R9 erase phase");
    strobe(1);
    chk(phase, 4, "R6 suspending");
    chk(int'(pause), 1, "R6 pause");
    cyc_n(4*SUS + 4);
    chk(phase, 5, "R6 suspended in time");
    strobe(0, 0);
    chk(int'(mask), 8'h24, "R10 mask held, add ignored");
    strobe(2);
    chk(phase, 3, "R7 resume to erase");
    strobe(1);
    chk(phase, 4, "R8 second suspend");
    cyc_n(4*SUS + 4);
    strobe(2);
    chk(phase, 3, "R8 second resume");
    strobe(5);
    chk(phase, 0, "R9 erase done");
    chk(int'(mask), 0, "R9 mask cleared");
    strobe(2);
    chk(phase, 0, "R7 resume in idle ignored");

    strobe(0, 1);
    strobe(3);
    chk(phase, 0, "R4 other aborts");
    chk(int'(mask), 0, "R4 mask cleared");
    chk(int'(abort), 1, "R4 abort pulse");

    strobe(0, 3);
    strobe(1);
    chk(phase, 5, "R5 window suspend");
    chk(int'(wopen), 0, "R5 window closed");
    chk(int'(pause), 1, "R5 pause");
    strobe(2);
    chk(int'(start), 1, "R5 resume starts erase");
    chk(phase, 2, "R5 preprog after resume");
    strobe(1);
    cyc_n(4*SUS + 4);
    strobe(2);
    chk(phase, 2, "R7 resume to preprog");

    strobe(6);
    chk(phase, 6, "R12 error");
    strobe(3);
    strobe(2);
    chk(phase, 6, "R12 error sticky");
    strobe(4);
    chk(phase, 0, "R12 reset cmd clears");

    strobe(0, 7);
    wait_start(n);
    cyc_n(1);
    strobe(7);
    chk(phase, 0, "R11 hw reset idle");
    chk(int'(mask), 0, "R11 mask cleared");
    chk(int'(abort), 1, "R11 abort pulse");

    cyc_n(4);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule